// File: doc/BRIEF.md
# Change-of-Flow Trace Buffer

This block keeps a short program-flow history for a processor debug unit, so that external debug software can rebuild the path the core took before it stopped. While the core runs, the block stores the address of every executed instruction that changed the flow of control. It keeps only a fixed number of the most recent ones and overwrites the oldest when full. It also samples three live pipeline addresses on every running cycle: the newly fetched instruction, the instruction on the program data bus, and the instruction held in the decode latch.

When the core enters debug mode, all of this state freezes. An external controller then reads the history one word per read strobe. An internal read pointer walks a fixed sequence: the three pipeline addresses first, then the stored change-of-flow addresses from oldest to newest. After the last word, the pointer returns to the first location. The controller must therefore read the whole sequence each time to stay aligned.

Top module: `flow_trace_buf`

## Requirements
- R1: After reset, `rd_data_o` is zero, every stored change-of-flow entry reads as zero, the read pointer is at location 0, and the next change-of-flow write goes to storage entry 0.
- R2: On every clock edge where `dbg_mode_i` is low, the three pipeline registers load `fetch_addr_i`, `bus_addr_i` and `latch_addr_i`. While `dbg_mode_i` is high, they hold their values.
- R3: A change-of-flow entry is stored only on an edge where `cof_valid_i` is high and `dbg_mode_i` is low, and the stored value is `cof_addr_i`. An address presented with `cof_valid_i` low is never stored.
- R4: The buffer holds the last DEPTH (default 12) stored addresses. Each write past DEPTH overwrites the oldest entry.
- R5: The readout order is fixed. Location 0 is the fetch address, location 1 is the program-data-bus address, and location 2 is the latch address. Locations 3 to DEPTH+2 are the change-of-flow slots from oldest to newest. When fewer than DEPTH writes have happened since reset, the unfilled slots read as zero and come first.
- R6: Read data is registered. The word for a strobe appears on `rd_data_o` one clock after that strobe is sampled, and it holds until the next accepted strobe.
- R7: Each accepted read strobe advances the read pointer by one. After DEPTH+3 accepted strobes, the pointer is back at location 0, so a second full pass returns the same sequence.
- R8: A read strobe sampled while `dbg_mode_i` is low is ignored. `rd_data_o` does not change and the read pointer does not move.
- R9: While `dbg_mode_i` is high, `cof_valid_i` is ignored, and reads do not change any stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_mode_i | input | 1 | Core is in debug mode: freeze capture and enable reads |
| fetch_addr_i | input | ADDR_W | Address of the newly fetched instruction |
| bus_addr_i | input | ADDR_W | Address of the instruction on the program data bus |
| latch_addr_i | input | ADDR_W | Address of the instruction in the decode latch |
| cof_valid_i | input | 1 | An executed change-of-flow instruction is reported this cycle |
| cof_addr_i | input | ADDR_W | Address of that change-of-flow instruction |
| rd_stb_i | input | 1 | Read strobe: fetch the next word of the sequence |
| rd_data_o | output | ADDR_W | Registered readout word |

## Verification
The bench builds the block with its default parameters: 24-bit addresses and 12 change-of-flow slots, which gives a 15-word readout. It sweeps every fill count from zero up to two full wraps plus one (0 to 25 writes), resetting before each count. This covers the partly filled buffer with leading zeros, the exactly full buffer, and repeated overwrite. Each sweep point reads the sequence twice: once with back-to-back strobes and once with gaps. This exercises pointer wrap, data holding between reads, and immunity of the frozen state to pipeline inputs and change-of-flow strobes that keep toggling during debug.

// File: rtl/flow_trace_pkg.sv
`timescale 1ns/1ps
package flow_trace_pkg;

    // Number of live pipeline addresses placed ahead of the history
    localparam int unsigned PIPE_SLOTS = 3;

    // Readout position of each pipeline address (order is behaviour)
    typedef enum logic [1:0] {
        SLOT_FETCH = 2'd0,
        SLOT_BUS   = 2'd1,
        SLOT_LATCH = 2'd2
    } pipe_slot_e;

endpackage

// File: rtl/pipe_snap.sv
`timescale 1ns/1ps
module pipe_snap
    import flow_trace_pkg::*;
#(
    parameter int unsigned ADDR_W = 24
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                freeze_i,
    input  logic [ADDR_W-1:0]                   fetch_i,
    input  logic [ADDR_W-1:0]                   bus_i,
    input  logic [ADDR_W-1:0]                   latch_i,
    output logic [PIPE_SLOTS-1:0][ADDR_W-1:0]   snap_o
);

    typedef struct packed {
        logic [PIPE_SLOTS-1:0][ADDR_W-1:0] slot;
    } snap_state_t;

    snap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!freeze_i) begin
            s_d.slot[int'(SLOT_FETCH)] = fetch_i;
            s_d.slot[int'(SLOT_BUS)]   = bus_i;
            s_d.slot[int'(SLOT_LATCH)] = latch_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign snap_o = s_q.slot;

    // R2
    snap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(snap_o));

    // R2
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze_i |=> (snap_o[int'(SLOT_FETCH)] == $past(fetch_i))
                   && (snap_o[int'(SLOT_LATCH)] == $past(latch_i)));

endmodule

// File: rtl/cof_ring.sv
`timescale 1ns/1ps
module cof_ring #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DEPTH  = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       freeze_i,
    input  logic                       valid_i,
    input  logic [ADDR_W-1:0]          addr_i,
    // age-ordered selection: 0 = oldest, DEPTH-1 = newest
    input  logic [$clog2(DEPTH)-1:0]   age_i,
    output logic [ADDR_W-1:0]          pick_o
);

    localparam int unsigned PW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [PW-1:0]                wptr;
    } ring_state_t;

    ring_state_t s_d, s_q;

    logic [PW:0]   raw_idx;
    logic [PW-1:0] phys_idx;

    always_comb begin
        s_d = s_q;
        if (valid_i && !freeze_i) begin
            s_d.mem[s_q.wptr] = addr_i;
            if (s_q.wptr == PW'(DEPTH - 1)) begin
                s_d.wptr = '0;
            end else begin
                s_d.wptr = s_q.wptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // the write pointer marks the oldest slot once the ring has wrapped
    assign raw_idx  = {1'b0, s_q.wptr} + {1'b0, age_i};
    assign phys_idx = PW'((raw_idx >= (PW+1)'(DEPTH)) ? raw_idx - (PW+1)'(DEPTH) : raw_idx);
    assign pick_o   = s_q.mem[phys_idx];

    // R4
    wptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.wptr < PW'(DEPTH));

    // R3
    wptr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !freeze_i) |=> (s_q.wptr != $past(s_q.wptr)));

    // R3
    wptr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(s_q.wptr));

    // R9
    ring_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> ($stable(s_q.mem) && $stable(s_q.wptr)));

    // R5
    age_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age_i < PW'(DEPTH));

endmodule

// File: rtl/read_seq.sv
`timescale 1ns/1ps
module read_seq
    import flow_trace_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DEPTH  = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                active_i,
    input  logic                                stb_i,
    input  logic [PIPE_SLOTS-1:0][ADDR_W-1:0]   snap_i,
    input  logic [ADDR_W-1:0]                   pick_i,
    output logic [$clog2(DEPTH)-1:0]            age_o,
    output logic [ADDR_W-1:0]                   data_o
);

    localparam int unsigned TOTAL = PIPE_SLOTS + DEPTH;
    localparam int unsigned RW    = $clog2(TOTAL);
    localparam int unsigned PW    = $clog2(DEPTH);

    typedef struct packed {
        logic [RW-1:0]     rptr;
        logic [ADDR_W-1:0] data;
    } rd_state_t;

    rd_state_t s_d, s_q;
    logic [ADDR_W-1:0] word_sel;

    // history slot addressed when the pointer is past the pipeline words
    assign age_o = (s_q.rptr >= RW'(PIPE_SLOTS)) ? PW'(s_q.rptr - RW'(PIPE_SLOTS)) : '0;

    always_comb begin
        case (s_q.rptr)
            RW'(SLOT_FETCH): word_sel = snap_i[int'(SLOT_FETCH)];
            RW'(SLOT_BUS):   word_sel = snap_i[int'(SLOT_BUS)];
            RW'(SLOT_LATCH): word_sel = snap_i[int'(SLOT_LATCH)];
            default:         word_sel = pick_i;
        endcase
    end

    always_comb begin
        s_d = s_q;
        if (active_i && stb_i) begin
            s_d.data = word_sel;
            if (s_q.rptr == RW'(TOTAL - 1)) begin
                s_d.rptr = '0;
            end else begin
                s_d.rptr = s_q.rptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_o = s_q.data;

    // R7
    rptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rptr < RW'(TOTAL));

    // R7
    rptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && stb_i && (s_q.rptr == RW'(TOTAL - 1))) |=> (s_q.rptr == '0));

    // R8
    ignore_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> ($stable(data_o) && $stable(s_q.rptr)));

    // R6
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_i |=> $stable(data_o));

    // R5
    first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && stb_i && (s_q.rptr == '0)) |=> (data_o == $past(snap_i[int'(SLOT_FETCH)])));

endmodule

// File: rtl/flow_trace_buf.sv
`timescale 1ns/1ps
module flow_trace_buf
    import flow_trace_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DEPTH  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_mode_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [ADDR_W-1:0] latch_addr_i,
    input  logic              cof_valid_i,
    input  logic [ADDR_W-1:0] cof_addr_i,
    input  logic              rd_stb_i,
    output logic [ADDR_W-1:0] rd_data_o
);

    localparam int unsigned PW = $clog2(DEPTH);

    logic [PIPE_SLOTS-1:0][ADDR_W-1:0] snap_w;
    logic [PW-1:0]                     age_w;
    logic [ADDR_W-1:0]                 pick_w;

    pipe_snap #(
        .ADDR_W (ADDR_W)
    ) u_snap (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (dbg_mode_i),
        .fetch_i  (fetch_addr_i),
        .bus_i    (bus_addr_i),
        .latch_i  (latch_addr_i),
        .snap_o   (snap_w)
    );

    cof_ring #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .freeze_i (dbg_mode_i),
        .valid_i  (cof_valid_i),
        .addr_i   (cof_addr_i),
        .age_i    (age_w),
        .pick_o   (pick_w)
    );

    read_seq #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (dbg_mode_i),
        .stb_i    (rd_stb_i),
        .snap_i   (snap_w),
        .pick_i   (pick_w),
        .age_o    (age_w),
        .data_o   (rd_data_o)
    );

    // R1
    reset_data_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (rd_data_o == '0));

endmodule

// File: tb/flow_trace_buf_test.sv
`timescale 1ns/1ps
module flow_trace_buf_test;

    localparam int AW    = 24;
    localparam int D     = 12;
    localparam int TOTAL = D + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dbg = 1'b0;
    logic [AW-1:0] fetch = '0, bus = '0, latch = '0;
    logic          cof_valid = 1'b0;
    logic [AW-1:0] cof_addr = '0;
    logic          rd_stb = 1'b0;
    logic [AW-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    logic [AW-1:0] exp_fetch, exp_bus, exp_latch;

    always #2.5 clk = ~clk;

    flow_trace_buf #(.ADDR_W(AW), .DEPTH(D)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_mode_i   (dbg),
        .fetch_addr_i (fetch),
        .bus_addr_i   (bus),
        .latch_addr_i (latch),
        .cof_valid_i  (cof_valid),
        .cof_addr_i   (cof_addr),
        .rd_stb_i     (rd_stb),
        .rd_data_o    (rd_data)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [AW-1:0] cof_val(input int n, input int i);
        return AW'(32'h400000 + n * 4096 + i + 1);
    endfunction

    // expected word at readout location j after n history writes
    function automatic logic [AW-1:0] expect_word(input int n, input int j);
        int k;
        if (j == 0) return exp_fetch;
        if (j == 1) return exp_bus;
        if (j == 2) return exp_latch;
        k = j - 3;
        if (n >= D)     return cof_val(n, n - D + k);
        if (k >= D - n) return cof_val(n, k - (D - n));
        return '0;
    endfunction

    // one clock: inputs set at a falling edge, outputs sampled at the next
    task automatic drive_cycle(input logic v, input logic [AW-1:0] a, input logic stb);
        cof_valid = v;
        cof_addr  = a;
        rd_stb    = stb;
        cyc++;
        if (!dbg) begin
            fetch = AW'(32'h100000 + cyc);
            bus   = AW'(32'h200000 + cyc);
            latch = AW'(32'h300000 + cyc);
            exp_fetch = fetch;
            exp_bus   = bus;
            exp_latch = latch;
        end else begin
            fetch = AW'(32'hF00000 + cyc);
            bus   = AW'(32'hE00000 + cyc);
            latch = AW'(32'hD00000 + cyc);
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        dbg = 1'b0;
        cof_valid = 1'b0;
        rd_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stimulus
        logic [AW-1:0] held;
        @(negedge clk);
        for (int n = 0; n <= 2 * D + 1; n++) begin
            do_reset();
            // R1: registered output cleared by reset
            check("R1 reset output", rd_data, '0);
            for (int i = 0; i < n; i++) begin
                // R3: valid write, then an invalid cycle carrying a junk address
                drive_cycle(1'b1, cof_val(n, i), 1'b0);
                drive_cycle(1'b0, AW'(32'hBAD000 + i), 1'b0);
            end
            // R8: strobes while running are ignored
            drive_cycle(1'b0, '0, 1'b1);
            drive_cycle(1'b0, '0, 1'b1);
            check("R8 strobe outside debug", rd_data, '0);
            // enter debug: capture freezes, change-of-flow strobes ignored (R9)
            dbg = 1'b1;
            drive_cycle(1'b1, AW'(32'hDEAD00 + n), 1'b0);
            // pass 0: back-to-back strobes
            for (int j = 0; j < TOTAL; j++) begin
                drive_cycle(1'b1, AW'(32'hC0F000 + j), 1'b1);
                // R5 R2 R4 R1 order, freeze and history content
                check(j < 3 ? "R5 pipeline word" : "R5 R4 history word",
                      rd_data, expect_word(n, j));
            end
            // pass 1: gapped strobes; pointer wrapped (R7) and contents intact (R9)
            for (int j = 0; j < TOTAL; j++) begin
                drive_cycle(1'b1, AW'(32'hC1F000 + j), 1'b1);
                check("R7 R9 second pass", rd_data, expect_word(n, j));
                held = rd_data;
                drive_cycle(1'b1, AW'(32'hC2F000 + j), 1'b0);
                // R6: data holds between strobes
                check("R6 hold", rd_data, held);
            end
            dbg = 1'b0;
            drive_cycle(1'b0, '0, 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule